// File: doc/BRIEF.md
# Supervisory Reset Generator with Hold-Off Stretch

This block merges every reason a processor subsystem must be held in reset into one reset state and drives it out as a complementary pair of outputs: one active-high and one active-low. It accepts four kinds of cause. The first is power-up, which is modelled by the block's own system reset. The second is a supply-in-tolerance flag from an external comparator. The third is an active-low pushbutton input. The fourth is a single-cycle pulse from an external watchdog counter.

Time is measured in ticks of a 1 ms enable strobe. The pushbutton is first synchronized and then debounced: it must read low for a run of consecutive ticks before it counts as pressed, and high for a run of consecutive ticks before it counts as released. A single hold-off counter serves every cause. The counter reloads on every cycle in which any cause is present and counts down only on ticks when none is present. Reset therefore ends a fixed number of ticks after the last cause goes away.

The supply flag and the watchdog pulse are expected to be synchronous to the block clock. The pushbutton may be asynchronous.

Top module: `supv_reset_gen`

## Requirements
- R1: While the synchronous system reset is low, rst_hi is 1 and rst_lo_n is 0. After the system reset is released with no cause present, reset stays asserted and falls on the clock edge that samples the 250th tick (HOLD_TICKS) after the release.
- R2: A cycle in which supply_ok is 0 makes rst_hi 1 from the next clock edge onward.
- R3: Once no cause is present, rst_hi falls on the clock edge that samples the 250th tick counted after the last clock edge at which a cause was present. It never falls earlier.
- R4: Cycles with tick_ms at 0 do not advance the hold-off, so reset stays asserted for as long as ticks are absent.
- R5: button_n passes through a 2-flop synchronizer. The button counts as pressed after the synchronized level reads 0 on 20 consecutive ticks (DEBOUNCE_TICKS), and a pressed button is a reset cause. A low pulse that lasts fewer than 20 ticks causes no reset.
- R6: A pressed button counts as released only after the synchronized level reads 1 on 20 consecutive ticks. A single low sample during that run restarts the count, and the 250-tick hold-off starts after the release.
- R7: A one-cycle wdog_expire pulse asserts rst_hi from the next edge, and reset lasts 250 ticks.
- R8: A wdog_expire pulse that arrives while reset is already active reloads the hold-off to 250 ticks, so reset can only lengthen.
- R9: rst_lo_n is the logical inverse of rst_hi in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset; models power-up |
| tick_ms | input | 1 | One-cycle enable strobe, nominally every 1 ms |
| supply_ok | input | 1 | 1 while the supply is inside tolerance (synchronous) |
| button_n | input | 1 | Active-low pushbutton, asynchronous |
| wdog_expire | input | 1 | One-cycle watchdog timeout pulse |
| rst_hi | output | 1 | Active-high reset |
| rst_lo_n | output | 1 | Active-low reset |

## Verification
The hardest situation to reach from the ports is a release that is interrupted. This covers a pushbutton that bounces low for one sample partway through its release run, and a watchdog pulse that lands in the middle of an existing hold-off. In both cases the outcome shows only as a later falling edge of the reset.

The stimulus drives these cases on exact cycles with the tick held on every cycle. It then predicts the falling edge from the latency of the synchronizer, the debounce run and the hold count, and checks the cycle just before that edge as well as the edge itself. A separate run gates the tick off to show that the hold-off freezes without ticks.

// File: rtl/supv_pkg.sv
// Package: shared types for the supervisory reset generator.
// Assumes: nothing beyond IEEE 1800-2017.
package supv_pkg;

    // Debounced view of the pushbutton.
    typedef enum logic {
        BTN_IDLE    = 1'b0,
        BTN_HELD    = 1'b1
    } btn_state_t;

    // Width needed to hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/supv_sync.sv
// Module: supv_sync
// Brings an asynchronous level into the clock domain through a chain of
// flops. Assumes STAGES >= 2 and that the input is a slow level.
// All flops reset to RESET_VAL.
module supv_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: shift the captured value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= RESET_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/supv_debounce.sv
// Module: supv_debounce
// Turns the synchronized active-low button level into a clean "held" flag.
// A level change must persist for RUN_TICKS consecutive ticks before the
// state flips. Any sample that matches the current state restarts the run.
// Assumes btn_lvl is already synchronous to clk.
module supv_debounce
    import supv_pkg::*;
#(
    parameter int unsigned RUN_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_lvl,
    output logic held
);

    localparam int unsigned CW = cnt_width(RUN_TICKS);
    localparam logic [CW-1:0] LAST = CW'(RUN_TICKS - 1);

    btn_state_t    state_q;
    logic [CW-1:0] run_q;
    logic          differs;

    // A sample "differs" when it points at the other debounced state.
    always_comb begin
        if (state_q == BTN_IDLE) differs = ~btn_lvl;
        else                     differs = btn_lvl;
    end

    // Count consecutive differing ticks; flip the state at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BTN_IDLE;
            run_q   <= '0;
        end else if (!differs) begin
            run_q   <= '0;
        end else if (tick) begin
            if (run_q == LAST) begin
                state_q <= (state_q == BTN_IDLE) ? BTN_HELD : BTN_IDLE;
                run_q   <= '0;
            end else begin
                run_q   <= run_q + 1'b1;
            end
        end
    end

    assign held = (state_q == BTN_HELD);

    // The run counter never reaches the run length itself.
    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LAST)
        else $error("run counter out of range");

    // A press is recognized only at the end of a full low run on a tick.
    p_press_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> ($past(!btn_lvl) && $past(tick) && $past(run_q) == LAST))
        else $error("press recognized without a full low run");

    // A release is recognized only at the end of a full high run on a tick.
    p_release_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held) |-> ($past(btn_lvl) && $past(tick) && $past(run_q) == LAST))
        else $error("release recognized without a full high run");

endmodule

// File: rtl/supv_hold_timer.sv
// Module: supv_hold_timer
// Single hold-off counter shared by all reset causes. It reloads to
// HOLD_TICKS on any cycle with a cause present, and counts down on ticks
// otherwise. Reset is active while the count is nonzero. The counter
// starts loaded at system reset, which models power-up.
module supv_hold_timer
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic active
);

    localparam int unsigned CW = cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic [CW-1:0] left_q;

    // Reload on a cause, otherwise step down once per tick until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= FULL;
        end else if (cause) begin
            left_q <= FULL;
        end else if (tick && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);

    // Any cause leaves reset active on the following cycle.
    p_cause_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> active)
        else $error("cause did not hold reset");

    // A cause always leaves a full hold-off, never a shortened one.
    p_full_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (left_q == FULL))
        else $error("hold-off not reloaded");

    // Without a tick or a cause, the remaining time does not move.
    p_frozen_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause && !tick) |=> $stable(left_q))
        else $error("hold-off moved without a tick");

    // Release happens only from the last unit, on a tick, with no cause.
    p_release_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(tick) && !$past(cause) && $past(left_q) == CW'(1)))
        else $error("reset released early");

    p_left_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= FULL)
        else $error("hold-off counter overflow");

endmodule

// File: rtl/supv_reset_gen.sv
// Module: supv_reset_gen (top)
// Merges supply fault, debounced pushbutton and watchdog pulse into one
// cause, stretches it through a shared hold-off counter and drives a
// complementary reset pair. Assumes supply_ok and wdog_expire are
// synchronous to clk; button_n may be asynchronous.
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_TICKS     = 250,
    parameter int unsigned DEBOUNCE_TICKS = 20,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic supply_ok,
    input  logic button_n,
    input  logic wdog_expire,
    output logic rst_hi,
    output logic rst_lo_n
);

    logic btn_lvl;
    logic btn_held;
    logic any_cause;
    logic hold_active;

    // Pushbutton into the clock domain.
    supv_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_btn_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (button_n),
        .q_sync  (btn_lvl)
    );

    // Pushbutton debounce.
    supv_debounce #(
        .RUN_TICKS (DEBOUNCE_TICKS)
    ) u_btn_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .btn_lvl (btn_lvl),
        .held    (btn_held)
    );

    // Merge every present cause into one request.
    always_comb begin
        any_cause = (~supply_ok) | btn_held | wdog_expire;
    end

    // Shared hold-off stretch.
    supv_hold_timer #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_ms),
        .cause  (any_cause),
        .active (hold_active)
    );

    // Complementary output pair.
    assign rst_hi   = hold_active;
    assign rst_lo_n = ~hold_active;

    p_supply_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (rst_hi && !rst_lo_n))
        else $error("supply fault did not assert reset");

    p_wdog_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_expire |=> rst_hi)
        else $error("watchdog pulse did not assert reset");

    p_button_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        btn_held |=> rst_hi)
        else $error("held button did not assert reset");

    p_power_up_r1: assert property (@(posedge clk)
        !rst_n |=> rst_hi)
        else $error("system reset did not assert reset");

endmodule

// File: tb/supv_reset_gen_test.sv
// Scoreboard bench: driver code pushes expected reset levels tagged with
// the cycle they must appear; a monitor pops and compares them.
module supv_reset_gen_test;

    typedef struct {
        int    cyc;
        bit    val;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b1;
    logic supply_ok = 1'b1;
    logic button_n = 1'b1;
    logic wdog_expire = 1'b0;
    logic rst_hi;
    logic rst_lo_n;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    supv_reset_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_ms     (tick_ms),
        .supply_ok   (supply_ok),
        .button_n    (button_n),
        .wdog_expire (wdog_expire),
        .rst_hi      (rst_hi),
        .rst_lo_n    (rst_lo_n)
    );

    task automatic expect_at(input int c, input bit v, input string r);
        exp_t e;
        e.cyc = c; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: sample 1 ns after each edge, pop due items, check R9 always.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        n_checks++;
        if (rst_lo_n !== ~rst_hi) begin
            n_fail++;
            $display("FAIL R9 cyc %0d: rst_lo_n=%b expected %b", cyc, rst_lo_n, ~rst_hi);
        end
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (e.cyc != cyc || rst_hi !== e.val) begin
                n_fail++;
                $display("FAIL %s cyc %0d (due %0d): rst_hi=%b expected %b",
                         e.req, cyc, e.cyc, rst_hi, e.val);
            end
        end
    end

    // Watchdog on the run itself.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung at cyc %0d, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int m;
        // R1: reset state, then power-up hold.
        expect_at(2, 1'b1, "R1");
        expect_at(4, 1'b1, "R1");
        wait_to(5);
        rst_n = 1'b1;
        expect_at(5 + 249, 1'b1, "R1");
        expect_at(5 + 250, 1'b0, "R1");
        wait_to(260);

        // R2/R3: supply fault for 30 cycles.
        n = cyc;
        supply_ok = 1'b0;
        expect_at(n + 1, 1'b1, "R2");
        wait_to(n + 30);
        supply_ok = 1'b1;
        expect_at(n + 30 + 249, 1'b1, "R3");
        expect_at(n + 30 + 250, 1'b0, "R3");
        wait_to(n + 290);

        // R5/R6: clean press and release.
        n = cyc;
        button_n = 1'b0;
        expect_at(n + 22, 1'b0, "R5");
        expect_at(n + 23, 1'b1, "R5");
        m = n + 60;
        wait_to(m);
        button_n = 1'b1;
        expect_at(m + 271, 1'b1, "R6");
        expect_at(m + 272, 1'b0, "R6");
        wait_to(m + 280);

        // R5: a 10-tick low glitch is ignored.
        n = cyc;
        button_n = 1'b0;
        expect_at(n + 5, 1'b0, "R5");
        wait_to(n + 10);
        button_n = 1'b1;
        expect_at(n + 25, 1'b0, "R5");
        expect_at(n + 40, 1'b0, "R5");
        wait_to(n + 50);

        // R6: bounce during release restarts the high run.
        n = cyc;
        button_n = 1'b0;
        expect_at(n + 23, 1'b1, "R6");
        m = n + 60;
        wait_to(m);
        button_n = 1'b1;
        wait_to(m + 10);
        button_n = 1'b0;
        wait_to(m + 11);
        button_n = 1'b1;
        expect_at(m + 282, 1'b1, "R6");
        expect_at(m + 283, 1'b0, "R6");
        wait_to(m + 290);

        // R7: single watchdog pulse.
        n = cyc;
        wdog_expire = 1'b1;
        expect_at(n + 1, 1'b1, "R7");
        wait_to(n + 1);
        wdog_expire = 1'b0;
        expect_at(n + 250, 1'b1, "R7");
        expect_at(n + 251, 1'b0, "R7");
        wait_to(n + 260);

        // R8: watchdog pulse during an active hold-off lengthens it.
        n = cyc;
        supply_ok = 1'b0;
        wait_to(n + 10);
        supply_ok = 1'b1;
        wait_to(n + 110);
        wdog_expire = 1'b1;
        wait_to(n + 111);
        wdog_expire = 1'b0;
        expect_at(n + 260, 1'b1, "R8");
        expect_at(n + 360, 1'b1, "R8");
        expect_at(n + 361, 1'b0, "R8");
        wait_to(n + 370);

        // R4: no ticks, hold-off frozen; ticks resume, release 250 later.
        n = cyc;
        tick_ms = 1'b0;
        wdog_expire = 1'b1;
        wait_to(n + 1);
        wdog_expire = 1'b0;
        expect_at(n + 200, 1'b1, "R4");
        expect_at(n + 300, 1'b1, "R4");
        wait_to(n + 300);
        tick_ms = 1'b1;
        expect_at(n + 549, 1'b1, "R4");
        expect_at(n + 550, 1'b0, "R4");
        wait_to(n + 560);

        done = 1'b1;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule